// File: doc/BRIEF.md
# Multiplexed-Address DRAM Strobe Decoder with Refresh Row Counter

This block is the control front end of a dynamic memory that takes its address in two halves over one shared bus. The four active-low strobes (row strobe, column strobe, write strobe, output strobe) and the shared address bus are sampled on a fast system clock. Falling and rising strobe edges are found by comparing each sample with the one before it. From the order of those edges the block latches the row and column addresses and classifies the access. The possible classes are a read, a write, a row-only refresh, a column-first refresh that uses an internal row counter, or a hidden refresh taken while read data stays valid.

A downstream array model uses the outputs. `row_q` and the single-cycle `row_act` pulse open and refresh a row. `col_q` selects a word within that row. `dout_en` gates the read data onto the data bus. An 11-bit internal counter supplies the refresh row for the two counter-driven refresh classes, and it steps once per such cycle.

Every output is registered. A change on the inputs shows at the outputs after the second rising clock edge: one edge samples the inputs and the next edge loads the output registers.

Top module: `dram_strobe_frontend`

## Requirements
- R1: After synchronous reset, `row_q`, `col_q`, `row_act` and `dout_en` are 0, `cyc_type` is IDLE (0), and the refresh counter holds 0.
- R2: When the row strobe falls while the column strobe is high, `row_q` takes the 11-bit bus value and `row_act` is high for exactly one clock. `cyc_type` becomes ROW_ONLY (3), `col_q` is unchanged and `dout_en` stays 0.
- R3: When the column strobe falls while the row strobe is low, `col_q` takes bus bits [9:0]. `cyc_type` becomes READ (1) if the write strobe is high, or WRITE (2) if it is low.
- R4: `dout_en` is 1 only when `cyc_type` is READ or HIDDEN, the column strobe is low, the output strobe is low and the write strobe is high.
- R5: If the write strobe falls while a READ cycle has both row and column strobes low, `cyc_type` becomes WRITE and `dout_en` goes to 0.
- R6: `dout_en` drops at the first update after the column strobe rises. With the output strobe held high it is never set.
- R7: When the row strobe falls while the column strobe is already low, with no read being held, the cycle is a counter refresh. This includes the case where both strobes fall in the same sample. `cyc_type` becomes COUNTER_REFRESH (4), `row_q` takes the counter value instead of the bus, `col_q` is unchanged, `dout_en` is 0, and the counter then increments.
- R8: The refresh counter counts from 0 to 2047, wraps to 0, and changes only on a counter-driven refresh.
- R9: If the row strobe rises while the column strobe stays low after a READ, the block holds the read: `cyc_type` stays READ and `dout_en` and `col_q` are unchanged. When the row strobe falls again, `cyc_type` becomes HIDDEN (5), `row_q` takes the counter value, the counter increments, `col_q` keeps the earlier column and `dout_en` stays 1.
- R10: When both the row and column strobes are sampled high, `cyc_type` returns to IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output strobe, active low |
| addr | input | 11 | Shared row/column address bus |
| row_q | output | 11 | Latched row (bus or refresh counter) |
| col_q | output | 10 | Latched column |
| cyc_type | output | 3 | Cycle class: 0 IDLE, 1 READ, 2 WRITE, 3 ROW_ONLY, 4 COUNTER_REFRESH, 5 HIDDEN |
| row_act | output | 1 | One-clock pulse when a row is opened |
| dout_en | output | 1 | Read data drive enable |

## Verification
The bench lowers both strobes in the same sample. A decoder that tests the column strobe only against the previous sample would treat that as a normal row-only access and then capture a column by mistake. It lowers the write strobe partway through a read and expects the output to drop; a design that classifies only at the column edge would keep driving the data bus. It holds the column strobe low across a row-strobe rise and fall. A design without the held-read state would report a plain counter refresh and drop `dout_en`, so read data would be lost. Finally, it runs the counter through 2047 to 0 and checks the wrap. A counter sized or wrapped wrongly shows up as a wrong refresh row.

// File: rtl/dram_fe_pkg.sv
package dram_fe_pkg;

  typedef enum logic [2:0] {
    CYC_IDLE     = 3'd0,
    CYC_READ     = 3'd1,
    CYC_WRITE    = 3'd2,
    CYC_ROW_ONLY = 3'd3,
    CYC_CTR_REF  = 3'd4,
    CYC_HIDDEN   = 3'd5
  } cyc_e;

endpackage

// File: rtl/dfe_strobe_sampler.sv
module dfe_strobe_sampler #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              s_ras,
  output logic              s_cas,
  output logic              s_we,
  output logic              s_oe,
  output logic [ADDR_W-1:0] s_addr,
  output logic              ras_fall,
  output logic              ras_rise,
  output logic              cas_fall,
  output logic              cas_rise
);

  logic p_ras, p_cas;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_ras  <= 1'b1;
      s_cas  <= 1'b1;
      s_we   <= 1'b1;
      s_oe   <= 1'b1;
      s_addr <= '0;
      p_ras  <= 1'b1;
      p_cas  <= 1'b1;
    end else begin
      s_ras  <= ras_n;
      s_cas  <= cas_n;
      s_we   <= we_n;
      s_oe   <= oe_n;
      s_addr <= addr;
      p_ras  <= s_ras;
      p_cas  <= s_cas;
    end
  end

  assign ras_fall = p_ras & ~s_ras;
  assign ras_rise = ~p_ras & s_ras;
  assign cas_fall = p_cas & ~s_cas;
  assign cas_rise = ~p_cas & s_cas;

endmodule

// File: rtl/dfe_refresh_ctr.sv
module dfe_refresh_ctr #(
  parameter int CTR_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  output logic [CTR_W-1:0] count
);

  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (step) count <= count + 1'b1;
  end

  AST_CTR_STEP: assert property (@(posedge clk) disable iff (rst)
    step |=> count == $past(count) + 1'b1); // R8
  AST_CTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(count)); // R8

endmodule

// File: rtl/dfe_cycle_fsm.sv
module dfe_cycle_fsm
  import dram_fe_pkg::*;
#(
  parameter int ROW_W = 11,
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s_ras,
  input  logic             s_cas,
  input  logic             s_we,
  input  logic             s_oe,
  input  logic [ROW_W-1:0] s_addr,
  input  logic             ras_fall,
  input  logic             ras_rise,
  input  logic             cas_fall,
  input  logic             cas_rise,
  input  logic [ROW_W-1:0] ref_row,
  output logic             ref_step,
  output logic [ROW_W-1:0] row_q,
  output logic [COL_W-1:0] col_q,
  output cyc_e             type_q,
  output logic             row_act,
  output logic             dout_en
);

  cyc_e             type_n;
  logic [ROW_W-1:0] row_n;
  logic [COL_W-1:0] col_n;
  logic             hold_q, hold_n;
  logic             act_n, dout_n;

  always_comb begin
    type_n   = type_q;
    row_n    = row_q;
    col_n    = col_q;
    hold_n   = hold_q;
    act_n    = 1'b0;
    ref_step = 1'b0;

    if (s_ras && s_cas) begin
      type_n = CYC_IDLE;
      hold_n = 1'b0;
    end
    if (ras_rise && !s_cas && (type_q == CYC_READ || type_q == CYC_HIDDEN))
      hold_n = 1'b1;
    if (cas_rise)
      hold_n = 1'b0;

    if (ras_fall) begin
      act_n = 1'b1;
      if (!s_cas) begin
        row_n    = ref_row;
        ref_step = 1'b1;
        type_n   = hold_q ? CYC_HIDDEN : CYC_CTR_REF;
        hold_n   = 1'b0;
      end else begin
        row_n  = s_addr;
        type_n = CYC_ROW_ONLY;
      end
    end else if (cas_fall && !s_ras) begin
      col_n  = s_addr[COL_W-1:0];
      type_n = s_we ? CYC_READ : CYC_WRITE;
    end else if (!s_ras && !s_cas && !s_we && type_q == CYC_READ) begin
      type_n = CYC_WRITE;
    end

    dout_n = !s_cas && !s_oe && s_we &&
             (type_n == CYC_READ || type_n == CYC_HIDDEN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      type_q  <= CYC_IDLE;
      row_q   <= '0;
      col_q   <= '0;
      hold_q  <= 1'b0;
      row_act <= 1'b0;
      dout_en <= 1'b0;
    end else begin
      type_q  <= type_n;
      row_q   <= row_n;
      col_q   <= col_n;
      hold_q  <= hold_n;
      row_act <= act_n;
      dout_en <= dout_n;
    end
  end

  AST_ACT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    row_act |=> !row_act); // R2
  AST_DOUT_CLASS: assert property (@(posedge clk) disable iff (rst)
    dout_en |-> (type_q == CYC_READ || type_q == CYC_HIDDEN)); // R4
  AST_REF_NO_DOUT: assert property (@(posedge clk) disable iff (rst)
    (type_q == CYC_CTR_REF || type_q == CYC_ROW_ONLY || type_q == CYC_WRITE) |-> !dout_en); // R7
  AST_ROW_ONLY_KEEPS_COL: assert property (@(posedge clk) disable iff (rst)
    (row_act && type_q == CYC_ROW_ONLY) |-> $stable(col_q)); // R2
  AST_REF_STEPS_CTR: assert property (@(posedge clk) disable iff (rst)
    (row_act && (type_q == CYC_CTR_REF || type_q == CYC_HIDDEN)) |-> $past(ref_step)); // R9

endmodule

// File: rtl/dram_strobe_frontend.sv
module dram_strobe_frontend #(
  parameter int ROW_W = 11,
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic [ROW_W-1:0] addr,
  output logic [ROW_W-1:0] row_q,
  output logic [COL_W-1:0] col_q,
  output logic [2:0]       cyc_type,
  output logic             row_act,
  output logic             dout_en
);

  import dram_fe_pkg::*;

  logic             s_ras, s_cas, s_we, s_oe;
  logic [ROW_W-1:0] s_addr;
  logic             ras_fall, ras_rise, cas_fall, cas_rise;
  logic [ROW_W-1:0] ref_row;
  logic             ref_step;
  cyc_e             type_q;

  dfe_strobe_sampler #(.ADDR_W(ROW_W)) u_sampler (
    .clk(clk), .rst(rst),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n), .addr(addr),
    .s_ras(s_ras), .s_cas(s_cas), .s_we(s_we), .s_oe(s_oe), .s_addr(s_addr),
    .ras_fall(ras_fall), .ras_rise(ras_rise),
    .cas_fall(cas_fall), .cas_rise(cas_rise)
  );

  dfe_refresh_ctr #(.CTR_W(ROW_W)) u_ctr (
    .clk(clk), .rst(rst), .step(ref_step), .count(ref_row)
  );

  dfe_cycle_fsm #(.ROW_W(ROW_W), .COL_W(COL_W)) u_fsm (
    .clk(clk), .rst(rst),
    .s_ras(s_ras), .s_cas(s_cas), .s_we(s_we), .s_oe(s_oe), .s_addr(s_addr),
    .ras_fall(ras_fall), .ras_rise(ras_rise),
    .cas_fall(cas_fall), .cas_rise(cas_rise),
    .ref_row(ref_row), .ref_step(ref_step),
    .row_q(row_q), .col_q(col_q), .type_q(type_q),
    .row_act(row_act), .dout_en(dout_en)
  );

  assign cyc_type = type_q;

  AST_IDLE_WHEN_HIGH: assert property (@(posedge clk) disable iff (rst)
    (s_ras && s_cas) |=> cyc_type == 3'd0); // R10

endmodule

// File: tb/dram_strobe_frontend_bench.sv
`timescale 1ns/1ps
module dram_strobe_frontend_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [10:0] addr = '0;
  logic [10:0] row_q;
  logic [9:0]  col_q;
  logic [2:0]  cyc_type;
  logic        row_act, dout_en;

  int n_chk = 0;
  int n_bad = 0;
  int exp_ctr = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dram_strobe_frontend u_dram_strobe_frontend (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .row_q(row_q), .col_q(col_q),
    .cyc_type(cyc_type), .row_act(row_act), .dout_en(dout_en)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Drive at a falling edge, then wait until both register stages have updated.
  task automatic apply(bit r, bit c, bit w, bit o, int a);
    ras_n = r; cas_n = c; we_n = w; oe_n = o; addr = a[10:0];
    repeat (2) @(negedge clk);
  endtask

  task automatic to_idle();
    apply(1, 1, 1, 1, 0);
    chk("R10", "type idle", cyc_type, 0);
  endtask

  task automatic t_reset();
    chk("R1", "row", row_q, 0);
    chk("R1", "col", col_q, 0);
    chk("R1", "type", cyc_type, 0);
    chk("R1", "act", row_act, 0);
    chk("R1", "dout", dout_en, 0);
  endtask

  task automatic t_read(int r, int c);
    apply(1, 1, 1, 0, r);
    apply(0, 1, 1, 0, r);
    chk("R2", "row latched", row_q, r);
    chk("R2", "act pulse", row_act, 1);
    @(negedge clk);
    chk("R2", "act one clock", row_act, 0);
    apply(0, 1, 1, 0, c);
    apply(0, 0, 1, 0, c);
    chk("R3", "read col", col_q, c & 10'h3ff);
    chk("R3", "type read", cyc_type, 1);
    chk("R4", "dout on", dout_en, 1);
    apply(0, 1, 1, 0, c);
    chk("R6", "dout off on cas rise", dout_en, 0);
    to_idle();
  endtask

  task automatic t_write(int r, int c);
    apply(0, 1, 0, 0, r);
    apply(0, 1, 0, 0, c);
    apply(0, 0, 0, 0, c);
    chk("R3", "write col", col_q, c & 10'h3ff);
    chk("R3", "type write", cyc_type, 2);
    chk("R4", "no dout on write", dout_en, 0);
    to_idle();
  endtask

  task automatic t_late_write();
    apply(0, 1, 1, 0, 11'h155);
    apply(0, 0, 1, 0, 11'h0aa);
    chk("R4", "dout before we", dout_en, 1);
    apply(0, 0, 0, 0, 11'h0aa);
    chk("R5", "type becomes write", cyc_type, 2);
    chk("R5", "dout off", dout_en, 0);
    to_idle();
  endtask

  task automatic t_oe_high();
    apply(0, 1, 1, 1, 11'h033);
    apply(0, 0, 1, 1, 11'h044);
    chk("R6", "type read oe high", cyc_type, 1);
    chk("R6", "no dout oe high", dout_en, 0);
    to_idle();
  endtask

  task automatic t_row_only(int r);
    int c0 = col_q;
    apply(0, 1, 1, 0, r);
    chk("R2", "row only row", row_q, r);
    chk("R2", "row only type", cyc_type, 3);
    chk("R2", "row only act", row_act, 1);
    chk("R2", "row only col kept", col_q, c0);
    chk("R2", "row only dout", dout_en, 0);
    to_idle();
  endtask

  task automatic cbr(bit check, bit same_sample);
    int c0 = col_q;
    if (!same_sample) apply(1, 0, 1, 0, 11'h7ff);
    apply(0, 0, 1, 0, 11'h123);
    if (check) begin
      chk("R7", "cbr row from counter", row_q, exp_ctr);
      chk("R7", "cbr type", cyc_type, 4);
      chk("R7", "cbr col kept", col_q, c0);
      chk("R7", "cbr dout", dout_en, 0);
    end
    exp_ctr = (exp_ctr + 1) % 2048;
    apply(1, 0, 1, 0, 0);
    apply(1, 1, 1, 0, 0);
  endtask

  task automatic t_hidden(int r, int c);
    apply(0, 1, 1, 0, r);
    apply(0, 0, 1, 0, c);
    chk("R9", "read before hide", dout_en, 1);
    apply(1, 0, 1, 0, 11'h3c3);
    chk("R9", "held type", cyc_type, 1);
    chk("R9", "held dout", dout_en, 1);
    apply(0, 0, 1, 0, 11'h3c3);
    chk("R9", "hidden type", cyc_type, 5);
    chk("R9", "hidden row", row_q, exp_ctr);
    chk("R9", "hidden col", col_q, c & 10'h3ff);
    chk("R9", "hidden dout", dout_en, 1);
    chk("R9", "hidden act", row_act, 1);
    exp_ctr = (exp_ctr + 1) % 2048;
    apply(0, 1, 1, 0, 0);
    chk("R6", "hidden dout off", dout_en, 0);
    to_idle();
  endtask

  task automatic t_wrap();
    while (exp_ctr != 2047) cbr(0, 0);
    cbr(1, 0);
    chk("R8", "counter at top", exp_ctr, 0);
    apply(1, 0, 1, 0, 0);
    apply(0, 0, 1, 0, 0);
    chk("R8", "counter wrapped", row_q, 0);
    exp_ctr = 1;
    to_idle();
    t_row_only(11'h400);
    cbr(1, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_read(11'h5a5, 11'h6b3);
    t_write(11'h00f, 11'h3fe);
    t_late_write();
    t_oe_high();
    t_row_only(11'h7f0);
    cbr(1, 0);
    cbr(1, 1);
    t_hidden(11'h101, 11'h2cd);
    cbr(1, 0);
    t_wrap();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule